// File: doc/BRIEF.md
# Multi-master two-wire bit engine with clock synchronization and arbitration

This block drives and watches one two-wire serial bus (clock line and data line, both open-drain, I2C style) at bit level. It works as the master side of the link. It issues start, repeated start, data bit and stop sequences when a framing block above it asks. Both lines are driven only through active-low pull enables. The real line levels come back through a synchronizer and set when each phase ends.

The clock is built cooperatively. The low phase counts a programmable number of system cycles. After that the block releases the clock line and waits until the synchronized line actually reads high, so any other device that holds the clock low stretches the low phase. The high phase is counted only from the moment the line is seen high. It ends early when some other device pulls the clock low, so the fastest master on the bus sets the high time.

At each rising clock edge the block samples the data line. For a transmitted bit it compares the sample with the level it drove. On a mismatch it reports lost arbitration, releases both lines and raises a fall-back flag so the framing block switches to target-side listening. The synchronized data level stays visible at all times. During a receive bit the data line is only listened to, so a target pulling it low is never an abort. If the clock is already low when a start is asked for, or is pulled low while the start condition is being set up, the block reports a bus error.

Top module: `tw_arb_clk`

## Requirements
- R1: During and straight after reset both pull enables are released (1), busy is 0, and step_done, arb_lost, bus_err and fallback are all 0.
- R2: A start request in idle, with the clock line seen high, pulls the data line low while the clock stays released for max(hi_div,1) cycles. The block then pulls the clock low and gives a one-cycle step_done.
- R3: A start request made while the synchronized clock line is low gives a one-cycle bus_err and no start. A clock pull-down by another device during the start setup gives bus_err 3 cycles after the pull (SYNC_STAGES+1). In both cases both lines are released and busy returns to 0.
- R4: After a bit, stop or repeated-start request is accepted from the hold state, the clock enable stays low for exactly max(lo_div,1) cycles. The clock line is seen high only once every holder has let go, so the low time is the longer of the two.
- R5: A completed clock-high phase keeps the clock line high for max(hi_div,1)+SYNC_STAGES+1 cycles after it rises, whether or not the low phase was stretched. The block then pulls the clock low and gives step_done.
- R6: If another device pulls the clock low during a bit's high phase, the block pulls the clock low and gives step_done SYNC_STAGES+1 cycles after the pull, without waiting for hi_div.
- R7: On a transmit bit (bit_rx=0) whose sampled data level differs from the driven level, arb_lost pulses SYNC_STAGES+1 cycles after the clock line rises. In the same cycle both enables are released, busy is 0 and fallback is 1, and there is no step_done.
- R8: On a receive bit (bit_rx=1) the block releases the data line, and rx_bit shows the data level sampled at the rising clock. A target pulling data low there is not an abort. A transmitted 0 read back as 0 is not an abort either.
- R9: A stop request holds data low through one low and one high clock phase. It then releases data while the clock is high, gives step_done and returns to idle with both lines released.
- R10: A repeated-start request releases data during a low phase and holds it high across a full high phase. It then pulls data low with the clock still high for max(hi_div,1) cycles, pulls the clock low and gives step_done.
- R11: A divider value of 0 acts as 1.
- R12: sda_mon follows the data line through the synchronizer: a change made between clock edges appears after SYNC_STAGES rising edges. The next accepted start clears fallback.
- R13: The data pull enable stays constant while the block has the clock released within a bit, stop or repeated-start high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw clock line level |
| sda_in | input | 1 | Raw data line level |
| hi_div | input | DIV_W | Clock-high phase length in system cycles (0 acts as 1) |
| lo_div | input | DIV_W | Clock-low phase length in system cycles (0 acts as 1) |
| start_req | input | 1 | Start in idle, repeated start in hold |
| stop_req | input | 1 | Stop request, taken in hold |
| bit_req | input | 1 | One-bit transfer request, taken in hold |
| bit_val | input | 1 | Bit level to transmit |
| bit_rx | input | 1 | 1 = receive bit, data line only listened to |
| scl_oe_n | output | 1 | Clock pull enable, 0 pulls the line low |
| sda_oe_n | output | 1 | Data pull enable, 0 pulls the line low |
| busy | output | 1 | Block is not idle |
| step_done | output | 1 | One-cycle pulse when a requested step completes |
| rx_bit | output | 1 | Data level sampled at the last bit's rising clock |
| arb_lost | output | 1 | One-cycle pulse on lost arbitration |
| bus_err | output | 1 | One-cycle pulse on a start conflict |
| fallback | output | 1 | Set on lost arbitration, cleared by the next start |
| sda_mon | output | 1 | Synchronized data line level |

## Verification
Most wrong internal states here appear at the ports within a single bit time. A wrong phase count or sync depth changes the number of cycles the clock line stays low or high, and it shows in the very next phase. A wrong arbitration decision shows as an abort that is missing or unwanted: arb_lost and the released enables appear, or fail to appear, exactly SYNC_STAGES+1 cycles after the clock rises. A wrong next-state choice after a high phase leaves the data line at the wrong level at the stop or repeated-start edge, or leaves step_done missing in the cycle the clock drops.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HOLD,
    ST_LOW,
    ST_WAITH,
    ST_HIGH
  } tw_state_e;

  typedef enum logic [1:0] {
    K_BIT,
    K_STOP,
    K_RSTART
  } tw_kind_e;

  // Phase ends on the cycle whose count is div-1; a zero divider ends at once.
  function automatic logic phase_last(input logic [15:0] cnt, input logic [15:0] div);
    if (div == 16'd0) return 1'b1;
    return cnt >= (div - 16'd1);
  endfunction

  // Abort rule: only when not listening, sampled level versus driven level.
  function automatic logic bit_mismatch(input logic drive_low, input logic sampled,
                                        input logic listening);
    return !listening && (sampled != !drive_low);
  endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '1;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '1;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tw_phase_cnt.sv
module tw_phase_cnt
  import tw_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] div,
  output logic         last
);
  logic [W-1:0] cnt;

  assign last = phase_last(16'(cnt), 16'(div));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (!last) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tw_arb_cmp.sv
module tw_arb_cmp
  import tw_pkg::*;
(
  input  logic sample_pt,
  input  logic is_data_bit,
  input  logic drive_low,
  input  logic listening,
  input  logic sda_seen,
  output logic lost
);
  assign lost = sample_pt && is_data_bit && bit_mismatch(drive_low, sda_seen, listening);
endmodule

// File: rtl/tw_arb_clk.sv
module tw_arb_clk
  import tw_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [DIV_W-1:0] hi_div,
  input  logic [DIV_W-1:0] lo_div,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             bit_req,
  input  logic             bit_val,
  input  logic             bit_rx,
  output logic             scl_oe_n,
  output logic             sda_oe_n,
  output logic             busy,
  output logic             step_done,
  output logic             rx_bit,
  output logic             arb_lost,
  output logic             bus_err,
  output logic             fallback,
  output logic             sda_mon
);
  localparam int LINES = 2;

  tw_state_e state, state_nx;
  tw_kind_e  kind, kind_nx;
  logic sda_pull, sda_pull_nx;
  logic listen, listen_nx;
  logic done_nx, lost_nx, err_nx, rxb_nx, fb_nx;

  // synchronized line levels
  logic [LINES-1:0] line_s;
  logic scl_s, sda_s;

  tw_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_in, sda_in}),
    .q    (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  // phase timer
  logic [DIV_W-1:0] div_sel;
  logic ph_clr, ph_last;
  assign div_sel = (state == ST_LOW) ? lo_div : hi_div;
  assign ph_clr  = (state_nx != state);

  tw_phase_cnt #(.W(DIV_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ph_clr),
    .div  (div_sel),
    .last (ph_last)
  );

  // named internal events
  logic ev_rise_seen, ev_high_cut, ev_setup_clash, ev_lost, ev_cut_bit, hi_phase;
  assign ev_rise_seen   = (state == ST_WAITH) && scl_s;
  assign ev_high_cut    = (state == ST_HIGH) && !scl_s;
  assign ev_setup_clash = (state == ST_SETUP) && !scl_s;
  assign ev_cut_bit     = ev_high_cut && (kind == K_BIT);
  assign hi_phase       = (state == ST_WAITH) || (state == ST_HIGH);

  tw_arb_cmp u_arb (
    .sample_pt  (ev_rise_seen),
    .is_data_bit(kind == K_BIT),
    .drive_low  (sda_pull),
    .listening  (listen),
    .sda_seen   (sda_s),
    .lost       (ev_lost)
  );

  always_comb begin
    state_nx    = state;
    kind_nx     = kind;
    sda_pull_nx = sda_pull;
    listen_nx   = listen;
    done_nx     = 1'b0;
    lost_nx     = 1'b0;
    err_nx      = 1'b0;
    rxb_nx      = rx_bit;
    fb_nx       = fallback;
    unique case (state)
      ST_IDLE: begin
        if (start_req) begin
          if (!scl_s) begin
            err_nx = 1'b1;
          end else begin
            state_nx    = ST_SETUP;
            sda_pull_nx = 1'b1;
            fb_nx       = 1'b0;
          end
        end
      end
      ST_SETUP: begin
        if (ev_setup_clash) begin
          state_nx    = ST_IDLE;
          sda_pull_nx = 1'b0;
          err_nx      = 1'b1;
        end else if (ph_last) begin
          state_nx = ST_HOLD;
          done_nx  = 1'b1;
        end
      end
      ST_HOLD: begin
        if (start_req) begin
          state_nx    = ST_LOW;
          kind_nx     = K_RSTART;
          sda_pull_nx = 1'b0;
          listen_nx   = 1'b1;
        end else if (stop_req) begin
          state_nx    = ST_LOW;
          kind_nx     = K_STOP;
          sda_pull_nx = 1'b1;
          listen_nx   = 1'b1;
        end else if (bit_req) begin
          state_nx    = ST_LOW;
          kind_nx     = K_BIT;
          sda_pull_nx = !bit_rx && !bit_val;
          listen_nx   = bit_rx;
        end
      end
      ST_LOW: begin
        if (ph_last) state_nx = ST_WAITH;
      end
      ST_WAITH: begin
        if (ev_rise_seen) begin
          if (ev_lost) begin
            state_nx    = ST_IDLE;
            sda_pull_nx = 1'b0;
            lost_nx     = 1'b1;
            fb_nx       = 1'b1;
          end else begin
            if (kind == K_BIT) rxb_nx = sda_s;
            state_nx = ST_HIGH;
          end
        end
      end
      ST_HIGH: begin
        if (ev_high_cut || ph_last) begin
          unique case (kind)
            K_BIT: begin
              state_nx = ST_HOLD;
              done_nx  = 1'b1;
            end
            K_STOP: begin
              state_nx    = ST_IDLE;
              sda_pull_nx = 1'b0;
              done_nx     = 1'b1;
            end
            default: begin
              state_nx    = ST_SETUP;
              sda_pull_nx = 1'b1;
            end
          endcase
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind      <= K_BIT;
      sda_pull  <= 1'b0;
      listen    <= 1'b1;
      step_done <= 1'b0;
      arb_lost  <= 1'b0;
      bus_err   <= 1'b0;
      rx_bit    <= 1'b1;
      fallback  <= 1'b0;
    end else begin
      state     <= state_nx;
      kind      <= kind_nx;
      sda_pull  <= sda_pull_nx;
      listen    <= listen_nx;
      step_done <= done_nx;
      arb_lost  <= lost_nx;
      bus_err   <= err_nx;
      rx_bit    <= rxb_nx;
      fallback  <= fb_nx;
    end
  end

  assign scl_oe_n = !((state == ST_HOLD) || (state == ST_LOW));
  assign sda_oe_n = !sda_pull;
  assign busy     = (state != ST_IDLE);
  assign sda_mon  = sda_s;
endmodule

// File: rtl/tw_arb_clk_chk.sv
module tw_arb_clk_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe_n,
  input logic sda_oe_n,
  input logic busy,
  input logic step_done,
  input logic arb_lost,
  input logic bus_err,
  input logic fallback,
  input logic ev_cut_bit,
  input logic hi_phase
);
  a_r3_err_releases: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (scl_oe_n && sda_oe_n && !busy));

  a_r7_loss_releases: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (scl_oe_n && sda_oe_n && fallback && !busy));

  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_done, arb_lost, bus_err}));

  a_r6_cut_ends_high: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cut_bit |=> (!scl_oe_n && step_done));

  a_r13_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_phase && $past(hi_phase)) |-> $stable(sda_oe_n));

  a_r9_stop_idle_free: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && !busy) |-> (scl_oe_n && sda_oe_n));
endmodule

bind tw_arb_clk tw_arb_clk_chk i_tw_arb_clk_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_oe_n  (scl_oe_n),
  .sda_oe_n  (sda_oe_n),
  .busy      (busy),
  .step_done (step_done),
  .arb_lost  (arb_lost),
  .bus_err   (bus_err),
  .fallback  (fallback),
  .ev_cut_bit(ev_cut_bit),
  .hi_phase  (hi_phase)
);

// File: tb/test_tw_arb_clk.sv
`timescale 1ns/1ps
module test_tw_arb_clk;
  localparam int DIV_W = 8;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] hi_div = 8'd2, lo_div = 8'd2;
  logic start_req = 0, stop_req = 0, bit_req = 0, bit_val = 0, bit_rx = 0;
  logic ext_scl_low = 0, ext_sda_low = 0;
  logic scl_in, sda_in;
  logic scl_oe_n, sda_oe_n, busy, step_done, rx_bit, arb_lost, bus_err, fallback, sda_mon;

  int total = 0, bad = 0;
  bit finished = 0;

  assign scl_in = scl_oe_n && !ext_scl_low;
  assign sda_in = sda_oe_n && !ext_sda_low;

  always #2.5 clk = ~clk;

  tw_arb_clk #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC)) i_tw_arb_clk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .hi_div(hi_div), .lo_div(lo_div),
    .start_req(start_req), .stop_req(stop_req), .bit_req(bit_req),
    .bit_val(bit_val), .bit_rx(bit_rx),
    .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n), .busy(busy), .step_done(step_done),
    .rx_bit(rx_bit), .arb_lost(arb_lost), .bus_err(bus_err), .fallback(fallback),
    .sda_mon(sda_mon)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff(input logic [DIV_W-1:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  function automatic bit scl_line();
    return scl_oe_n && !ext_scl_low;
  endfunction

  function automatic bit sda_line();
    return sda_oe_n && !ext_sda_low;
  endfunction

  // count negedges with the clock line low; releases an external holder at index ext_len
  task automatic run_low(input int ext_len, output int lowc);
    int i = 1;
    lowc = 0;
    while (lowc < 2000) begin
      if (ext_len > 0 && i >= ext_len) ext_scl_low = 1'b0;
      if (scl_line()) break;
      lowc++; i++;
      @(negedge clk);
    end
  endtask

  task automatic do_start();
    int n = 0;
    @(negedge clk); start_req = 1;
    @(negedge clk); start_req = 0;
    while (scl_line() && !sda_line() && n < 2000) begin n++; @(negedge clk); end
    chk(n == eff(hi_div), "R2 start setup length", n, eff(hi_div));
    chk(step_done && !scl_oe_n, "R2 start done with clock low", {step_done, scl_oe_n}, 2);
  endtask

  task automatic do_bit(input bit val, input bit rx, input bit xsda, input int ext_len,
                        input bit expect_lost);
    int lowc, highc = 0, exp_low;
    bit lost = 0;
    ext_sda_low = xsda;
    ext_scl_low = (ext_len > 0);
    @(negedge clk); bit_req = 1; bit_val = val; bit_rx = rx;
    @(negedge clk); bit_req = 0;
    run_low(ext_len, lowc);
    exp_low = (ext_len - 1 > eff(lo_div)) ? ext_len - 1 : eff(lo_div);
    chk(lowc == exp_low, "R4/R11 low length", lowc, exp_low);
    while (scl_line() && highc < 2000) begin
      if (arb_lost) begin lost = 1; break; end
      highc++;
      @(negedge clk);
    end
    if (expect_lost) begin
      chk(lost, "R7 arb_lost raised", lost, 1);
      chk(highc == SYNC + 1, "R7 loss at sample point", highc, SYNC + 1);
      chk(scl_oe_n && sda_oe_n && !busy && fallback, "R7 released and fallback",
          {scl_oe_n, sda_oe_n, busy, fallback}, 4'b1101);
      chk(!step_done, "R7 no step_done", step_done, 0);
    end else begin
      chk(!lost, "R8 no abort", lost, 0);
      chk(highc == eff(hi_div) + SYNC + 1, "R5/R11 high length", highc, eff(hi_div) + SYNC + 1);
      chk(step_done, "R5 bit done", step_done, 1);
      chk(rx_bit == !(xsda || (!rx && !val)), "R8 sampled bit", rx_bit, !(xsda || (!rx && !val)));
    end
    ext_sda_low = 0;
  endtask

  task automatic do_bit_cut(input int h);
    int lowc, highc = 0;
    @(negedge clk); bit_req = 1; bit_val = 1; bit_rx = 0;
    @(negedge clk); bit_req = 0;
    run_low(0, lowc);
    while (scl_line() && highc < h) begin highc++; @(negedge clk); end
    ext_scl_low = 1;
    for (int k = 1; k <= SYNC + 1; k++) begin
      @(negedge clk);
      if (k <= SYNC) chk(!step_done, "R6 no early done", step_done, 0);
      else chk(step_done && !scl_oe_n, "R6 cut ends high phase", {step_done, scl_oe_n}, 2);
    end
    @(negedge clk); ext_scl_low = 0;
  endtask

  task automatic do_stop();
    int lowc, n = 0;
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
    chk(!sda_line(), "R9 data low in stop low phase", sda_line(), 0);
    run_low(0, lowc);
    chk(lowc == eff(lo_div), "R4 stop low length", lowc, eff(lo_div));
    while (scl_line() && !sda_line() && n < 2000) begin n++; @(negedge clk); end
    chk(n == eff(hi_div) + SYNC + 1, "R9 stop high with data low", n, eff(hi_div) + SYNC + 1);
    chk(scl_line() && sda_line() && step_done && !busy, "R9 stop edge and idle",
        {scl_line(), sda_line(), step_done, busy}, 4'b1110);
  endtask

  task automatic do_rstart();
    int lowc, n = 0, m = 0;
    @(negedge clk); start_req = 1;
    @(negedge clk); start_req = 0;
    chk(sda_line(), "R10 data released in low phase", sda_line(), 1);
    run_low(0, lowc);
    while (scl_line() && sda_line() && n < 2000) begin n++; @(negedge clk); end
    chk(n == eff(hi_div) + SYNC + 1, "R10 high with data high", n, eff(hi_div) + SYNC + 1);
    while (scl_line() && !sda_line() && m < 2000) begin m++; @(negedge clk); end
    chk(m == eff(hi_div), "R10 setup with data low", m, eff(hi_div));
    chk(step_done && !scl_oe_n, "R10 done with clock low", {step_done, scl_oe_n}, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    static int lo_set[5] = '{0, 1, 2, 3, 5};
    static int hi_set[4] = '{0, 1, 2, 4};
    repeat (2) @(negedge clk);
    chk(scl_oe_n && sda_oe_n && !busy && !step_done && !arb_lost && !bus_err && !fallback,
        "R1 reset state", {scl_oe_n, sda_oe_n, busy, step_done, arb_lost, bus_err, fallback}, 7'b1100000);
    rst_n = 1;
    @(negedge clk);
    chk(scl_oe_n && sda_oe_n && !busy && !fallback, "R1 after reset",
        {scl_oe_n, sda_oe_n, busy, fallback}, 4'b1100);

    // R12 monitor path
    ext_sda_low = 1;
    @(negedge clk); chk(sda_mon == 1, "R12 monitor not yet", sda_mon, 1);
    @(negedge clk); chk(sda_mon == 0, "R12 monitor follows", sda_mon, 0);
    ext_sda_low = 0;
    repeat (3) @(negedge clk);

    // sweep of dividers
    foreach (lo_set[a]) begin
      foreach (hi_set[b]) begin
        lo_div = DIV_W'(lo_set[a]);
        hi_div = DIV_W'(hi_set[b]);
        do_start();
        do_bit(1, 0, 0, 0, 0);
        do_bit(0, 0, 0, 0, 0);
        do_bit(0, 1, 1, 0, 0);
        do_bit(0, 1, 0, 0, 0);
        do_bit(0, 0, 1, 0, 0);
        do_bit(1, 0, 0, eff(lo_div) + 6, 0);
        do_rstart();
        do_bit(1, 0, 0, 0, 0);
        do_stop();
        repeat (4) @(negedge clk);
      end
    end

    // arbitration loss, then fallback cleared by new start
    lo_div = 3; hi_div = 4;
    do_start();
    do_bit(1, 0, 1, 0, 1);
    repeat (2) @(negedge clk);
    chk(fallback && scl_oe_n && sda_oe_n, "R7 stays released", {fallback, scl_oe_n, sda_oe_n}, 7);
    repeat (4) @(negedge clk);
    do_start();
    chk(!fallback, "R12 fallback cleared by start", fallback, 0);

    // fastest master ends high phase
    hi_div = 20;
    do_bit_cut(5);
    do_stop();
    repeat (4) @(negedge clk);

    // start refused while clock held low
    ext_scl_low = 1;
    repeat (4) @(negedge clk);
    start_req = 1;
    @(negedge clk); start_req = 0;
    chk(bus_err && !busy && scl_oe_n && sda_oe_n, "R3 start on low clock",
        {bus_err, busy, scl_oe_n, sda_oe_n}, 4'b1011);
    @(negedge clk);
    chk(!bus_err, "R3 error is a pulse", bus_err, 0);
    ext_scl_low = 0;
    repeat (4) @(negedge clk);

    // clock pulled low during start setup
    @(negedge clk); start_req = 1;
    @(negedge clk); start_req = 0;
    @(negedge clk); ext_scl_low = 1;
    for (int k = 1; k <= SYNC + 1; k++) begin
      @(negedge clk);
      if (k <= SYNC) chk(!bus_err, "R3 no early error", bus_err, 0);
      else chk(bus_err && !busy && scl_oe_n && sda_oe_n, "R3 setup clash",
               {bus_err, busy, scl_oe_n, sda_oe_n}, 4'b1011);
    end
    ext_scl_low = 0;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule